// File: doc/BRIEF.md
# Line Memory Bring-Up Sequencer

This block brings a dual-port line memory into a usable state after the supply comes up, after the supply dips out of range, and after the memory clock stalls. It runs on a free-running reference clock. It receives a synchronous supply-good flag and the memory clock itself as a level, which it samples. It drives the memory's power-on-reset release line and its active-low write-reset and read-reset lines, and it raises a ready flag once the memory may be used.

After the supply is good, the power-on-reset line is held low for a fixed time. That time is derived from the reference clock frequency and a hold time in microseconds. The hold only advances while the memory clock is toggling. Once the line is released, each reset line stays low until a set number of memory-clock rising edges has been seen against it. The count is cumulative, so gaps in the memory clock pause it and do not restart it. When the memory clock stalls in service, ready drops. Both reset lines then stay low until a set number of fresh rising edges has been seen.

Every pin is a plain level. The block carries no data, so there is no valid/ready stream and no back-pressure.

Top module: `lmem_bringup`

## Requirements
- R1: Out of reset, por_rel, wrst_n, rrst_n and ready are all 0.
- R2: While supply_ok is 0, por_rel stays 0 whether or not the memory clock runs.
- R3: With the memory clock running throughout, por_rel rises exactly HOLD_CYC+2 reference edges after the first edge that samples supply_ok high, where HOLD_CYC = REF_KHZ*HOLD_US/1000. It then stays high while supply_ok stays 1.
- R4: A stall of the memory clock during the hold restarts the hold time from zero once the clock resumes.
- R5: While por_rel is 0, wrst_n and rrst_n are 0. After por_rel rises, a memory-clock rise counts toward a line if por_rel is 1 and that line is still 0 at the second reference edge after the rise. wrst_n goes to 1 after exactly WRST_CYC counted rises, and rrst_n after exactly RRST_CYC counted rises.
- R6: Gaps in the memory clock while resets are being counted, including gaps longer than the stall window, neither clear nor advance the counts.
- R7: ready stays 0 until both reset lines have completed. With unequal targets, the line with the smaller target is released first while ready is still 0.
- R8: When ready is 1 and the memory clock shows no edge for STALL_CYC = REF_KHZ*STALL_NS/1000000 reference cycles, ready falls to 0 and both reset lines go to 0. por_rel stays 1.
- R9: A memory-clock gap shorter than the stall window leaves ready at 1.
- R10: After a stall, both reset lines stay 0 until REC_CYC memory-clock rises have been seen. Then ready returns to 1 and both lines go to 1.
- R11: supply_ok at 0 in any state forces por_rel, wrst_n, rrst_n and ready to 0 from the next reference edge. It clears both reset counts, so a later bring-up counts the full targets again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-in-range flag, synchronous to clk |
| mem_clk | input | 1 | Memory clock level, sampled through a synchronizer |
| por_rel | output | 1 | Power-on-reset line to the memory (1 = released) |
| wrst_n | output | 1 | Write-reset line, active low |
| rrst_n | output | 1 | Read-reset line, active low |
| ready | output | 1 | Memory usable |

## Verification
The bench times the power-on release to the exact edge, so a hold counter that is off by one or that ignores the memory clock would show. It stops the memory clock in the middle of the hold. A timer that keeps counting through the stall would release the power-on line about a hundred cycles early. It also stops the clock in the middle of reset counting, for longer than the stall window. A design that cleared or restarted its counts there would apply more reset edges than the target. With unequal targets, a design that tied the two lines together shows up. A supply drop in the middle of counting checks that the next bring-up counts both targets in full and does not finish early on stale counts.

// File: rtl/lmem_bringup_pkg.sv
package lmem_bringup_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_COUNT = 3'd2,
    ST_READY = 3'd3,
    ST_STALL = 3'd4
  } bu_state_e;

  function automatic int unsigned cnt_width(input int unsigned target);
    return (target < 1) ? 1 : $clog2(target + 1);
  endfunction

endpackage

// File: rtl/lmem_edge_sync.sv
module lmem_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic toggle
);
  localparam int unsigned PW = STAGES + 1;

  logic [PW-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[PW-2:0], din};
  end

  assign rise   = pipe[STAGES-1] & ~pipe[STAGES];
  assign toggle = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/lmem_idle_mon.sv
module lmem_idle_mon
  import lmem_bringup_pkg::*;
#(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic stalled
);
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] idle_cnt;

  // Starts saturated: the clock counts as stopped until an edge is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_cnt <= TOP;
    else if (toggle)         idle_cnt <= '0;
    else if (idle_cnt != TOP) idle_cnt <= idle_cnt + 1'b1;
  end

  assign stalled = (idle_cnt == TOP);
endmodule

// File: rtl/lmem_tally.sv
module lmem_tally
  import lmem_bringup_pkg::*;
#(
  parameter int unsigned TARGET = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int unsigned CW = cnt_width(TARGET);
  localparam logic [CW-1:0] TOP = CW'(TARGET);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !done)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TOP);
endmodule

// File: rtl/lmem_bringup.sv
module lmem_bringup
  import lmem_bringup_pkg::*;
#(
  parameter int unsigned REF_KHZ  = 100000,
  parameter int unsigned HOLD_US  = 1000,
  parameter int unsigned STALL_NS = 200,
  parameter int unsigned WRST_CYC = 100,
  parameter int unsigned RRST_CYC = 100,
  parameter int unsigned REC_CYC  = 1,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic mem_clk,
  output logic por_rel,
  output logic wrst_n,
  output logic rrst_n,
  output logic ready
);
  localparam int unsigned HOLD_CYC  = REF_KHZ * HOLD_US / 1000;
  localparam int unsigned STALL_CYC = REF_KHZ * STALL_NS / 1000000;

  bu_state_e state, state_nx;

  logic mclk_rise, mclk_tog, stalled;
  logic hold_done, w_done, r_done, rec_done;

  lmem_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(mem_clk),
    .rise(mclk_rise), .toggle(mclk_tog)
  );

  lmem_idle_mon #(.LIMIT(STALL_CYC)) u_idle (
    .clk(clk), .rst_n(rst_n), .toggle(mclk_tog), .stalled(stalled)
  );

  // Hold timer only advances while the memory clock is alive.
  lmem_tally #(.TARGET(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_HOLD || stalled),
    .inc(1'b1),
    .done(hold_done)
  );

  // Cumulative reset-edge counts, cleared only from the supply wait.
  lmem_tally #(.TARGET(WRST_CYC)) u_wcnt (
    .clk(clk), .rst_n(rst_n),
    .clr(state == ST_WAIT || !supply_ok),
    .inc(mclk_rise && state == ST_COUNT),
    .done(w_done)
  );

  lmem_tally #(.TARGET(RRST_CYC)) u_rcnt (
    .clk(clk), .rst_n(rst_n),
    .clr(state == ST_WAIT || !supply_ok),
    .inc(mclk_rise && state == ST_COUNT),
    .done(r_done)
  );

  lmem_tally #(.TARGET(REC_CYC)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_STALL),
    .inc(mclk_rise),
    .done(rec_done)
  );

  always_comb begin
    state_nx = state;
    if (!supply_ok) begin
      state_nx = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT:  state_nx = ST_HOLD;
        ST_HOLD:  if (hold_done) state_nx = ST_COUNT;
        ST_COUNT: if (w_done && r_done) state_nx = ST_READY;
        ST_READY: if (stalled) state_nx = ST_STALL;
        ST_STALL: if (rec_done) state_nx = ST_READY;
        default:  state_nx = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= state_nx;
  end

  assign por_rel = (state == ST_COUNT) || (state == ST_READY) || (state == ST_STALL);
  assign wrst_n  = (state == ST_READY) || (state == ST_COUNT && w_done);
  assign rrst_n  = (state == ST_READY) || (state == ST_COUNT && r_done);
  assign ready   = (state == ST_READY);
endmodule

// File: rtl/lmem_bringup_chk.sv
module lmem_bringup_chk #(
  parameter int unsigned HOLD_CYC = 100000
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic stalled,
  input logic por_rel,
  input logic wrst_n,
  input logic rrst_n,
  input logic ready
);
  logic [31:0] live_run;

  // Consecutive cycles with supply good, line held and clock alive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_run <= '0;
    else if (supply_ok && !por_rel && !stalled) begin
      if (live_run != 32'hFFFF_FFFF) live_run <= live_run + 1'b1;
    end else live_run <= '0;
  end

  a_r2_no_release_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !por_rel);

  a_r3_release_after_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_rel) |-> (live_run >= HOLD_CYC));

  a_r5_lines_low_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    !por_rel |-> (!wrst_n && !rrst_n));

  a_r7_ready_implies_released: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (wrst_n && rrst_n && por_rel));

  a_r8_stall_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && stalled) |=> !ready);

  a_r11_loss_clears_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!ready && !wrst_n && !rrst_n));
endmodule

bind lmem_bringup lmem_bringup_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .stalled(stalled),
  .por_rel(por_rel), .wrst_n(wrst_n), .rrst_n(rrst_n), .ready(ready)
);

// File: tb/tb_lmem_bringup.sv
module tb_lmem_bringup;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 200;   // 100000 kHz * 2 us / 1000
  localparam int WT   = 8;
  localparam int RT   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic mclk = 1'b0;
  logic mrun = 1'b0;
  logic por_rel, wrst_n, rrst_n, ready;

  int total = 0;
  int bad = 0;
  int wc = 0;
  int rc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmem_bringup #(
    .REF_KHZ(100000), .HOLD_US(2), .STALL_NS(200),
    .WRST_CYC(WT), .RRST_CYC(RT), .REC_CYC(1), .SYNC_STG(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mem_clk(mclk),
    .por_rel(por_rel), .wrst_n(wrst_n), .rrst_n(rrst_n), .ready(ready)
  );

  // Memory clock: toggles every 5 reference cycles while mrun is set.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (mrun) begin
        if (ph == 4) begin mclk = ~mclk; ph = 0; end
        else ph = ph + 1;
      end
    end
  end

  // Counts rises that qualify for each line (R5 rule: 2nd reference edge).
  always @(posedge mclk) begin
    repeat (2) @(posedge clk);
    #1;
    if (por_rel && !wrst_n) wc++;
    if (por_rel && !rrst_n) rc++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; supply_ok = 1'b0; mrun = 1'b1;
    cyc(5);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(30);
  endtask

  task automatic wait_por();
    for (int i = 0; i < 3000; i++) begin
      if (por_rel) break;
      cyc(1);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 3000; i++) begin
      if (ready) break;
      cyc(1);
    end
  endtask

  // {supply, mrun, cycles[15:0], por, wrst_n, rrst_n, ready}
  localparam logic [21:0] VEC [9] = '{
    {1'b0, 1'b1, 16'd50,  4'b0000},  // R2 no supply
    {1'b1, 1'b1, 16'd100, 4'b0000},  // R3 mid hold
    {1'b1, 1'b1, 16'd150, 4'b1000},  // R5 counting
    {1'b1, 1'b1, 16'd60,  4'b1100},  // R7 write line first
    {1'b1, 1'b1, 16'd100, 4'b1111},  // R5 both done
    {1'b1, 1'b0, 16'd10,  4'b1111},  // R9 short gap
    {1'b1, 1'b0, 16'd40,  4'b1000},  // R8 stall
    {1'b1, 1'b1, 16'd50,  4'b1111},  // R10 recovery
    {1'b0, 1'b1, 16'd2,   4'b0000}   // R11 supply loss
  };
  localparam int VEC_REQ [9] = '{2, 3, 5, 7, 5, 9, 8, 10, 11};

  initial begin
    mrun = 1'b1;
    cyc(5);
    // R1 reset state
    chk("R1 por_rel", por_rel, 0);
    chk("R1 wrst_n", wrst_n, 0);
    chk("R1 rrst_n", rrst_n, 0);
    chk("R1 ready", ready, 0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      supply_ok = VEC[i][21];
      mrun      = VEC[i][20];
      cyc(int'(VEC[i][19:4]));
      chk($sformatf("R%0d vec%0d", VEC_REQ[i], i),
          {28'd0, por_rel, wrst_n, rrst_n, ready}, {28'd0, VEC[i][3:0]});
    end

    // R3 exact release edge, then R7 ordering and R5 exact counts
    do_reset();
    wc = 0; rc = 0;
    @(negedge clk);
    supply_ok = 1'b1;
    begin
      int n = 0;
      for (int i = 0; i < 1000; i++) begin
        @(posedge clk); #1;
        n++;
        if (por_rel) break;
      end
      chk("R3 release edge", n, HOLD + 2);
    end
    for (int i = 0; i < 3000; i++) begin
      if (wrst_n) break;
      cyc(1);
    end
    chk("R7 read line still low", rrst_n, 0);
    chk("R7 ready still low", ready, 0);
    wait_ready();
    cyc(20);
    chk("R5 write count", wc, WT);
    chk("R5 read count", rc, RT);

    // R6 long gap during counting keeps the running totals
    do_reset();
    wc = 0; rc = 0;
    @(negedge clk);
    supply_ok = 1'b1;
    wait_por();
    cyc(35);
    @(negedge clk);
    mrun = 1'b0;
    cyc(60);
    chk("R6 ready low in gap", ready, 0);
    chk("R6 write line low in gap", wrst_n, 0);
    @(negedge clk);
    mrun = 1'b1;
    wait_ready();
    cyc(20);
    chk("R6 write count", wc, WT);
    chk("R6 read count", rc, RT);

    // R4 stall during hold restarts the hold timer
    do_reset();
    @(negedge clk);
    supply_ok = 1'b1;
    cyc(100);
    chk("R4 held before stall", por_rel, 0);
    @(negedge clk);
    mrun = 1'b0;
    cyc(40);
    @(negedge clk);
    mrun = 1'b1;
    cyc(150);
    chk("R4 hold restarted", por_rel, 0);
    cyc(100);
    chk("R4 released after full hold", por_rel, 1);

    // R11 supply loss during counting clears the counts
    do_reset();
    @(negedge clk);
    supply_ok = 1'b1;
    wait_por();
    cyc(40);
    @(negedge clk);
    supply_ok = 1'b0;
    cyc(1);
    chk("R11 por dropped", por_rel, 0);
    chk("R11 write line low", wrst_n, 0);
    cyc(20);
    wc = 0; rc = 0;
    @(negedge clk);
    supply_ok = 1'b1;
    wait_ready();
    cyc(20);
    chk("R11 write recount", wc, WT);
    chk("R11 read recount", rc, RT);
    chk("R11 ready again", ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule